// File: doc/BRIEF.md
# Quarter-Wave Sine Table Generator

The block turns a phase word into a signed sine sample. One sine period is split into 1024 equal phase steps. A read-only table holds only the first rising quarter of the wave. The rest of the cycle is rebuilt from that quarter. The two top phase bits pick the quadrant. The lower eight bits either address the table directly or address it in reverse. In the negative half-cycle the magnitude read from the table is negated.

The table holds 15-bit unsigned magnitudes. It is filled when the design elaborates, by a computation that runs inside the design, so no data file is needed. Entry `i` holds the value of `32767·sin(2π(i+0.5)/1024)`, rounded. The half-step offset makes the mirror exactly symmetric. A caller presents a phase together with a valid strobe. Two clock cycles later the matching signed 16-bit sample appears with its own valid flag. A new phase can be accepted on every cycle.

Top module: `qsine_gen`

## Requirements
- R1: For every phase p in 0..1023, the output sample is within 1 LSB of 32767·sin(2π(p+0.5)/1024).
- R2: Phase bits [9:8] select the quadrant. In quadrant 0 (bits 00), bits [7:0] address the table directly, so the samples rise with the phase and are never negative.
- R3: In quadrants 1 and 3, the table is addressed with the bitwise complement of bits [7:0]. As a result, the sample at phase 256+a equals the sample at phase 255−a, for a in 0..255.
- R4: In quadrants 2 and 3 (bit 9 set), the output is the two's-complement negation of the table value. As a result, the sample at phase p+512 equals minus the sample at phase p, and is never positive.
- R5: The output valid flag rises exactly two clock edges after the edge that samples an input valid. The sample presented with it belongs to that input.
- R6: The output sample never takes the value −32768. Its magnitude is never larger than 32767.
- R7: While reset (active low) is held, the output valid flag is 0 and the sample is 0.
- R8: A phase presented with the valid strobe low is ignored. The output sample keeps its last value and the output valid flag stays low.
- R9: One phase is accepted on every clock cycle. A back-to-back stream of N phases gives N valid samples, in the same order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Marks `in_phase` as a phase to convert |
| in_phase | input | 10 | Phase word; bits [9:8] give the quadrant |
| out_vld | output | 1 | Marks `out_sample` as a new result |
| out_sample | output | 16 | Signed sine sample, two's complement |

## Verification
The hardest points to reach are the quadrant seams. These are the phases next to 255/256, 511/512 and 767/768. There the mirrored address wraps from one end of the table to the other, and the sign flips at the same moment. A fault in the complement or in the negation shows up only in a few samples there. The stimulus therefore streams all 1024 phases back to back, one per cycle. Each result is compared with a real-valued sine model. The mirror and negation identities are also checked pairwise across the whole sweep, so every seam is covered twice. A separate single-pulse pass with idle cycles shows the latency and that phases arriving without the strobe are ignored.

// File: rtl/qsine_pkg.sv
package qsine_pkg;

   localparam real TWO_PI = 6.283185307179586;

   typedef enum logic [1:0] {
      QUAD_RISE  = 2'd0,
      QUAD_FALL  = 2'd1,
      QUAD_NRISE = 2'd2,
      QUAD_NFALL = 2'd3
   } quad_e;

   // Rounded magnitude for quarter-table slot idx, sampled at the half-step centre
   function automatic int unsigned qsine_entry(input int unsigned idx,
                                               input int unsigned phase_w,
                                               input int unsigned mag_w);
      real ang;
      real amp;
      ang = TWO_PI * (real'(idx) + 0.5) / real'(64'd1 << phase_w);
      amp = real'((64'd1 << mag_w) - 64'd1) * $sin(ang);
      return int'($rtoi(amp + 0.5));
   endfunction

endpackage

// File: rtl/qsine_addr.sv
module qsine_addr
   import qsine_pkg::*;
#(
   parameter int PHASE_W = 10,
   localparam int ADDR_W = PHASE_W - 2
) (
   input  logic [PHASE_W-1:0] phase,
   output logic [ADDR_W-1:0]  addr,
   output logic               neg
);

   quad_e quad;

   always_comb begin
      quad = quad_e'(phase[PHASE_W-1 -: 2]);
      unique case (quad)
         QUAD_RISE:  begin addr =  phase[ADDR_W-1:0]; neg = 1'b0; end
         QUAD_FALL:  begin addr = ~phase[ADDR_W-1:0]; neg = 1'b0; end
         QUAD_NRISE: begin addr =  phase[ADDR_W-1:0]; neg = 1'b1; end
         default:    begin addr = ~phase[ADDR_W-1:0]; neg = 1'b1; end
      endcase
   end

endmodule

// File: rtl/qsine_rom.sv
module qsine_rom
   import qsine_pkg::*;
#(
   parameter int PHASE_W = 10,
   parameter int MAG_W   = 15,
   localparam int ADDR_W = PHASE_W - 2,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   output logic [MAG_W-1:0]  dout
);

   logic [MAG_W-1:0] mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mem[i] = MAG_W'(qsine_entry(i, PHASE_W, MAG_W));
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en) begin
         dout <= mem[addr];
      end
   end

endmodule

// File: rtl/qsine_sign.sv
module qsine_sign #(
   parameter int MAG_W = 15,
   parameter int OUT_W = 16,
   localparam int PAD_W = OUT_W - MAG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic             neg,
   input  logic [MAG_W-1:0] mag,
   output logic             out_vld,
   output logic [OUT_W-1:0] sample
);

   logic signed [OUT_W-1:0] ext;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("qsine_sign: OUT_W must exceed MAG_W");
      end
   endgenerate

   assign ext = signed'({{PAD_W{1'b0}}, mag});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         sample  <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            sample <= neg ? -ext : ext;
         end
      end
   end

   p_neg_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && neg) |=> ($signed(sample) <= 0));

   p_pos_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !neg) |=> ($signed(sample) >= 0));

   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> ($stable(sample) && !out_vld));

endmodule

// File: rtl/qsine_gen.sv
module qsine_gen
   import qsine_pkg::*;
#(
   parameter int PHASE_W = 10,
   parameter int MAG_W   = 15,
   parameter int OUT_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [PHASE_W-1:0] in_phase,
   output logic             out_vld,
   output logic [OUT_W-1:0] out_sample
);

   localparam int ADDR_W = PHASE_W - 2;
   localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

   generate
      if (PHASE_W < 3) begin : g_bad_phase
         $error("qsine_gen: PHASE_W must be at least 3");
      end
      if (MAG_W < 2 || OUT_W <= MAG_W) begin : g_bad_mag
         $error("qsine_gen: need MAG_W >= 2 and OUT_W > MAG_W");
      end
   endgenerate

   logic [ADDR_W-1:0] rom_addr;
   logic              neg_c;
   logic [MAG_W-1:0]  rom_mag;
   logic              s1_vld;
   logic              s1_neg;

   qsine_addr #(.PHASE_W(PHASE_W)) u_addr (
      .phase (in_phase),
      .addr  (rom_addr),
      .neg   (neg_c)
   );

   qsine_rom #(.PHASE_W(PHASE_W), .MAG_W(MAG_W)) u_rom (
      .clk   (clk),
      .rd_en (in_vld),
      .addr  (rom_addr),
      .dout  (rom_mag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_neg <= 1'b0;
      end else begin
         s1_vld <= in_vld;
         if (in_vld) begin
            s1_neg <= neg_c;
         end
      end
   end

   qsine_sign #(.MAG_W(MAG_W), .OUT_W(OUT_W)) u_sign (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (s1_vld),
      .neg     (s1_neg),
      .mag     (rom_mag),
      .out_vld (out_vld),
      .sample  (out_sample)
   );

   // cycles since reset release, saturating, so $past never reaches before reset
   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
   end

   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (out_vld == $past(in_vld, 2)));

   p_no_most_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_sample != MOST_NEG));

   p_reset_clear_r7: assert property (@(posedge clk)
      !rst_n |=> (!out_vld && out_sample == '0));

endmodule

// File: tb/qsine_gen_tb.sv
module qsine_gen_tb;

   localparam int N = 1024;
   localparam real TWO_PI = 6.283185307179586;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [9:0]  in_phase = '0;
   logic        out_vld;
   logic [15:0] out_sample;

   int total = 0;
   int bad = 0;
   int got [N];
   int n_got = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   qsine_gen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_vld     (in_vld),
      .in_phase   (in_phase),
      .out_vld    (out_vld),
      .out_sample (out_sample)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model(input int p);
      real v;
      v = 32767.0 * $sin(TWO_PI * (real'(p) + 0.5) / 1024.0);
      return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
   endfunction

   initial begin
      #2_000_000;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int held;
      // R7: reset holds outputs clear
      repeat (3) @(negedge clk);
      check(out_vld == 1'b0, "R7 vld", int'(out_vld), 0);
      check(out_sample == 16'd0, "R7 sample", int'($signed(out_sample)), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: single pulse latency
      in_phase = 10'd100; in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0; in_phase = 10'd700;
      check(out_vld == 1'b0, "R5 early", int'(out_vld), 0);
      @(negedge clk);
      check(out_vld == 1'b1, "R5 on time", int'(out_vld), 1);
      check($signed(out_sample) == model(100), "R5 data", int'($signed(out_sample)), model(100));
      @(negedge clk);
      check(out_vld == 1'b0, "R5 single", int'(out_vld), 0);

      // R8: idle phases ignored
      held = int'($signed(out_sample));
      for (int k = 0; k < 6; k++) begin
         in_phase = 10'(k * 171 + 600);
         @(negedge clk);
      end
      check(out_vld == 1'b0, "R8 vld", int'(out_vld), 0);
      check(int'($signed(out_sample)) == held, "R8 hold", int'($signed(out_sample)), held);

      // R9/R1: back-to-back sweep of every phase
      for (int p = 0; p < N + 2; p++) begin
         if (out_vld && n_got < N) begin
            got[n_got] = int'($signed(out_sample));
            n_got++;
         end
         in_vld = (p < N);
         in_phase = 10'(p);
         @(negedge clk);
      end
      in_vld = 1'b0;
      if (out_vld && n_got < N) begin
         got[n_got] = int'($signed(out_sample));
         n_got++;
      end
      @(negedge clk);
      check(n_got == N, "R9 count", n_got, N);
      check(out_vld == 1'b0, "R9 stream end", int'(out_vld), 0);

      for (int p = 0; p < n_got; p++) begin
         int d;
         d = got[p] - model(p);
         check(d <= 1 && d >= -1, "R1", got[p], model(p));
         check(got[p] != -32768 && got[p] <= 32767 && got[p] >= -32767, "R6", got[p], model(p));
      end
      if (n_got == N) begin
         for (int a = 0; a < 256; a++) begin
            check(got[a] >= 0, "R2 quadrant0 sign", got[a], model(a));
            if (a > 0) check(got[a] >= got[a-1], "R2 rising", got[a], got[a-1]);
            check(got[256 + a] == got[255 - a], "R3 mirror", got[256 + a], got[255 - a]);
         end
         for (int p = 0; p < 512; p++) begin
            check(got[p + 512] == -got[p], "R4 negate", got[p + 512], -got[p]);
         end
         check(got[255] == got[256], "R3 seam", got[256], got[255]);
         check(got[511] == -got[512], "R4 seam", got[512], -got[511]);
      end

      // R7: reset again mid-run clears outputs
      in_vld = 1'b1; in_phase = 10'd300;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(out_vld == 1'b0 && out_sample == 16'd0, "R7 rerun", int'($signed(out_sample)), 0);
      in_vld = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule